// File: doc/BRIEF.md
# Debug Control Register with Probe Access Handshake

This block is the target-side model of a 32-bit debug control register that an external debug probe reads and writes through a scan data register, alongside a read-only implementation-code register that describes the debug unit. The host side is reduced to three ports. A capture strobe loads one of the two registers into a capture output. An update strobe applies a 32-bit shifted word. A select input picks which register is captured. The scan state machine itself is not part of the block.

Each control bit follows its own write rule. Some bits are ordinary read/write, some read-only, some can only be cleared by writing zero, and some can only be set by writing one. Some of these bits are tied to a processor stub: a pending processor access with its direction, a reset-occurred event, and a debug-mode status. The register drives break-request, processor-reset, peripheral-reset and two probe-enable outputs. A processor access that arrives while one is already pending is held in a one-deep slot. It becomes pending after the host completes the current access.

Top module: `dbg_ctl_reg`

## Requirements
- R1: A capture strobe loads the live control value (select 0) or the implementation code (select 1) into the capture output, visible after the next clock edge. Update writes take effect on the edge that samples the update strobe.
- R2: After reset the control register reads 0x8000_0000, and the break, processor-reset, peripheral-reset, probe-enable, probe-trap and access-pending outputs are all low.
- R3: Bit 31 (reset occurred) is set by a processor reset event. An update with bit 31 at 0 clears it, and an update with bit 31 at 1 leaves it unchanged.
- R4: Bit 18 (access pending) is set by a processor access request and is mirrored on the access-pending output. An update with bit 18 at 0 clears it, and an update with bit 18 at 1 has no effect.
- R5: Bit 19 is read-only and holds the direction of the pending access: 1 for a processor write, 0 for a processor read.
- R6: A request that arrives while bit 18 is set is held. It becomes pending, with its own direction, one cycle after the host clears bit 18.
- R7: Bit 12 (break request) is set by writing 1, is unaffected by writing 0, and is cleared one cycle after the processor reports debug mode. It drives the break output.
- R8: Bit 3 is read-only and reflects the processor's debug-mode input; writes to it have no effect.
- R9: Bits 15 (probe enable) and 14 (probe trap) are plain read/write bits and drive their outputs.
- R10: Bits 16 and 20 are read/write; while set they drive the processor-reset and peripheral-reset outputs respectively.
- R11: All bits other than 31, 20, 19, 18, 16, 15, 14, 12 and 3 read as zero and ignore writes.
- R12: The implementation code has the debug version in bits 31:29 (0 = 2.0 or earlier, 1 = 2.5, 2 = 2.6, 3 = 3.1), bit 14 set for no DMA support and bit 0 set for a 64-bit core. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_shift_in | input | 32 | Word shifted in by the host |
| dr_update | input | 1 | Applies dr_shift_in under the per-bit rules |
| dr_capture | input | 1 | Loads the selected register into dr_capture_val |
| dr_cap_sel | input | 1 | 0 selects the control register, 1 the implementation code |
| dr_capture_val | output | 32 | Captured value returned to the host |
| cpu_acc_req | input | 1 | One-cycle processor access request |
| cpu_acc_wr | input | 1 | Direction of the request, 1 = processor write |
| cpu_reset_evt | input | 1 | One-cycle processor reset event |
| cpu_in_debug | input | 1 | Processor is in debug mode |
| acc_pending_o | output | 1 | Access pending (bit 18) |
| brk_req_o | output | 1 | Break request (bit 12) |
| cpu_rst_o | output | 1 | Processor reset request (bit 16) |
| per_rst_o | output | 1 | Peripheral reset request (bit 20) |
| probe_en_o | output | 1 | Probe servicing enable (bit 15) |
| probe_trap_o | output | 1 | Probe trap enable (bit 14) |

## Verification
Every write rule and every processor event lands on the first clock edge after it is presented. The capture output is one edge behind its strobe. A held access request is the one result that needs two edges, the first to clear bit 18 and the second to promote the held request. The bench drives all stimulus on falling edges and samples on the falling edge after the expected rising edge. For the held request it reads the pending output in both the cycle where it is low and the cycle where it returns high. Sweeps of one-hot writes, each starting from reset, give every bit position a known prior state, so the expected register value can be computed as the written word masked by the writable and settable bit masks.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;

   localparam int CTL_W = 32;

   // bit positions that the processor stub and outputs decode
   localparam int B_RST_SEEN  = 31;
   localparam int B_PER_RST   = 20;
   localparam int B_ACC_DIR   = 19;
   localparam int B_ACC_PEND  = 18;
   localparam int B_CPU_RST   = 16;
   localparam int B_PROBE_EN  = 15;
   localparam int B_PROBE_TRP = 14;
   localparam int B_BRK_REQ   = 12;
   localparam int B_IN_DEBUG  = 3;

   typedef enum logic [2:0] {
      RULE_NONE,
      RULE_RO,
      RULE_RW,
      RULE_W0C,
      RULE_W1S
   } bit_rule_e;

   function automatic bit_rule_e rule_of(input int idx);
      case (idx)
         B_RST_SEEN:                              return RULE_W0C;
         B_BRK_REQ:                               return RULE_W1S;
         B_ACC_DIR, B_ACC_PEND, B_IN_DEBUG:       return RULE_RO;
         B_PER_RST, B_CPU_RST, B_PROBE_EN,
         B_PROBE_TRP:                             return RULE_RW;
         default:                                 return RULE_NONE;
      endcase
   endfunction

   function automatic logic [CTL_W-1:0] impl_word(input int ver, input bit no_dma,
                                                  input bit wide_core);
      logic [CTL_W-1:0] w;
      w = '0;
      w[CTL_W-1 -: 3] = ver[2:0];
      w[14] = no_dma;
      w[0] = wide_core;
      return w;
   endfunction

endpackage

// File: rtl/dbg_bit_cell.sv
module dbg_bit_cell
   import dbg_ctl_pkg::*;
#(
   parameter bit_rule_e RULE    = RULE_RW,
   parameter bit        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_d,
   input  logic hw_set,
   input  logic hw_clr,
   input  logic hw_val,
   output logic q
);

   logic unused_cell;
   assign unused_cell = ^{wr_en, wr_d, hw_set, hw_clr, hw_val};

   generate
      if (RULE == RULE_NONE) begin : g_none
         assign q = 1'b0;
      end else if (RULE == RULE_RO) begin : g_ro
         assign q = hw_val;
      end else begin : g_stored
         logic q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_r <= RST_VAL;
            end else if (RULE == RULE_RW) begin
               if (wr_en) q_r <= wr_d;
            end else if (RULE == RULE_W0C) begin
               if (hw_set)             q_r <= 1'b1;
               else if (wr_en && !wr_d) q_r <= 1'b0;
            end else begin
               if (hw_clr)             q_r <= 1'b0;
               else if (wr_en && wr_d)  q_r <= 1'b1;
            end
         end
         assign q = q_r;
      end
   endgenerate

endmodule

// File: rtl/dbg_acc_track.sv
module dbg_acc_track (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic req_wr,
   input  logic host_clr,
   output logic pending,
   output logic dir
);

   logic held, held_dir;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending  <= 1'b0;
         dir      <= 1'b0;
         held     <= 1'b0;
         held_dir <= 1'b0;
      end else if (pending) begin
         if (host_clr) pending <= 1'b0;
         if (req && !held) begin
            held     <= 1'b1;
            held_dir <= req_wr;
         end
      end else if (held) begin
         pending  <= 1'b1;
         dir      <= held_dir;
         held     <= req;
         held_dir <= req_wr;
      end else if (req) begin
         pending <= 1'b1;
         dir     <= req_wr;
      end
   end

endmodule

// File: rtl/dbg_impcode.sv
module dbg_impcode
   import dbg_ctl_pkg::*;
#(
   parameter int VERSION   = 2,
   parameter bit NO_DMA    = 1'b1,
   parameter bit WIDE_CORE = 1'b0
) (
   output logic [CTL_W-1:0] code
);

   generate
      if (VERSION < 0 || VERSION > 3) begin : g_bad_version
         $error("dbg_impcode: VERSION must be 0 to 3");
      end
      if (CTL_W != 32) begin : g_bad_width
         $error("dbg_impcode: register width must be 32");
      end
   endgenerate

   assign code = impl_word(VERSION, NO_DMA, WIDE_CORE);

endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
   import dbg_ctl_pkg::*;
#(
   parameter int VERSION   = 2,
   parameter bit NO_DMA    = 1'b1,
   parameter bit WIDE_CORE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] dr_shift_in,
   input  logic             dr_update,
   input  logic             dr_capture,
   input  logic             dr_cap_sel,
   output logic [CTL_W-1:0] dr_capture_val,
   input  logic             cpu_acc_req,
   input  logic             cpu_acc_wr,
   input  logic             cpu_reset_evt,
   input  logic             cpu_in_debug,
   output logic             acc_pending_o,
   output logic             brk_req_o,
   output logic             cpu_rst_o,
   output logic             per_rst_o,
   output logic             probe_en_o,
   output logic             probe_trap_o
);

   logic [CTL_W-1:0] hw_set, hw_clr, hw_val, ctl_live, impl_code;
   logic             acc_pend, acc_dir;

   dbg_impcode #(.VERSION(VERSION), .NO_DMA(NO_DMA), .WIDE_CORE(WIDE_CORE)) u_impl (
      .code (impl_code)
   );

   dbg_acc_track u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (cpu_acc_req),
      .req_wr   (cpu_acc_wr),
      .host_clr (dr_update && !dr_shift_in[B_ACC_PEND]),
      .pending  (acc_pend),
      .dir      (acc_dir)
   );

   always_comb begin
      hw_set = '0;
      hw_clr = '0;
      hw_val = '0;
      hw_set[B_RST_SEEN] = cpu_reset_evt;
      hw_clr[B_BRK_REQ]  = cpu_in_debug;
      hw_val[B_IN_DEBUG] = cpu_in_debug;
      hw_val[B_ACC_PEND] = acc_pend;
      hw_val[B_ACC_DIR]  = acc_dir;
   end

   generate
      for (genvar i = 0; i < CTL_W; i++) begin : g_bit
         dbg_bit_cell #(.RULE(rule_of(i)), .RST_VAL(i == B_RST_SEEN)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (dr_update),
            .wr_d   (dr_shift_in[i]),
            .hw_set (hw_set[i]),
            .hw_clr (hw_clr[i]),
            .hw_val (hw_val[i]),
            .q      (ctl_live[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dr_capture_val <= '0;
      else if (dr_capture) dr_capture_val <= dr_cap_sel ? impl_code : ctl_live;
   end

   assign acc_pending_o = ctl_live[B_ACC_PEND];
   assign brk_req_o     = ctl_live[B_BRK_REQ];
   assign cpu_rst_o     = ctl_live[B_CPU_RST];
   assign per_rst_o     = ctl_live[B_PER_RST];
   assign probe_en_o    = ctl_live[B_PROBE_EN];
   assign probe_trap_o  = ctl_live[B_PROBE_TRP];

endmodule

// File: rtl/dbg_ctl_reg_chk.sv
module dbg_ctl_reg_chk
   import dbg_ctl_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [CTL_W-1:0] dr_shift_in,
   input logic             dr_update,
   input logic             cpu_acc_req,
   input logic             cpu_reset_evt,
   input logic             cpu_in_debug,
   input logic             acc_pending_o,
   input logic             brk_req_o,
   input logic             cpu_rst_o,
   input logic             per_rst_o,
   input logic [CTL_W-1:0] ctl_live
);

   localparam logic [CTL_W-1:0] USED_BITS = 32'h801D_D008;

   p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_reset_evt |=> ctl_live[B_RST_SEEN]);

   p_flag_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_update && dr_shift_in[B_RST_SEEN] && ctl_live[B_RST_SEEN]) |=> ctl_live[B_RST_SEEN]);

   p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_acc_req && !acc_pending_o) |=> acc_pending_o);

   p_brk_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_in_debug |=> !brk_req_o);

   p_brk_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req_o && !cpu_in_debug) |=> brk_req_o);

   p_rst_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dr_update |=> (cpu_rst_o == $past(dr_shift_in[B_CPU_RST]))
                 && (per_rst_o == $past(dr_shift_in[B_PER_RST])));

   p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dr_update) |-> ((ctl_live & ~USED_BITS) == '0));

endmodule

bind dbg_ctl_reg dbg_ctl_reg_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .dr_shift_in   (dr_shift_in),
   .dr_update     (dr_update),
   .cpu_acc_req   (cpu_acc_req),
   .cpu_reset_evt (cpu_reset_evt),
   .cpu_in_debug  (cpu_in_debug),
   .acc_pending_o (acc_pending_o),
   .brk_req_o     (brk_req_o),
   .cpu_rst_o     (cpu_rst_o),
   .per_rst_o     (per_rst_o),
   .ctl_live      (ctl_live)
);

// File: tb/test_dbg_ctl_reg.sv
`timescale 1ns/1ps
module test_dbg_ctl_reg;

   localparam int T_VER = 2;
   localparam bit T_NODMA = 1'b1;
   localparam bit T_WIDE = 1'b0;
   localparam logic [31:0] RW_M   = 32'h0011_C000;
   localparam logic [31:0] BRK_M  = 32'h0000_1000;
   localparam logic [31:0] FLAG_M = 32'h8000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] shift_in = '0;
   logic upd = 1'b0, cap = 1'b0, sel = 1'b0;
   logic [31:0] cap_val;
   logic acc_req = 1'b0, acc_wr = 1'b0, rst_evt = 1'b0, in_dbg = 1'b0;
   logic pend, brk, crst, prst, pen, ptrap;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dbg_ctl_reg #(.VERSION(T_VER), .NO_DMA(T_NODMA), .WIDE_CORE(T_WIDE)) i_dbg_ctl_reg (
      .clk(clk), .rst_n(rst_n), .dr_shift_in(shift_in), .dr_update(upd),
      .dr_capture(cap), .dr_cap_sel(sel), .dr_capture_val(cap_val),
      .cpu_acc_req(acc_req), .cpu_acc_wr(acc_wr), .cpu_reset_evt(rst_evt),
      .cpu_in_debug(in_dbg), .acc_pending_o(pend), .brk_req_o(brk),
      .cpu_rst_o(crst), .per_rst_o(prst), .probe_en_o(pen), .probe_trap_o(ptrap)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic write(input logic [31:0] v);
      @(negedge clk) begin shift_in = v; upd = 1'b1; end
      @(negedge clk) upd = 1'b0;
   endtask

   task automatic read(input logic s, output logic [31:0] v);
      @(negedge clk) begin sel = s; cap = 1'b1; end
      @(negedge clk) cap = 1'b0;
      v = cap_val;
   endtask

   task automatic access(input logic w);
      @(negedge clk) begin acc_req = 1'b1; acc_wr = w; end
      @(negedge clk) acc_req = 1'b0;
   endtask

   function automatic logic [31:0] outs(input logic [31:0] c);
      return {26'd0, c[18], c[15], c[14], c[16], c[20], c[12]};
   endfunction

   function automatic logic [31:0] live_outs();
      return {26'd0, pend, pen, ptrap, crst, prst, brk};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1 actual=hang expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, e;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      chk("R2 outputs", live_outs(), 32'd0);
      read(1'b0, v); chk("R2 ctl", v, FLAG_M);

      // R12, R1 implementation code capture
      e = (32'(T_VER) << 29) | (32'(T_NODMA) << 14) | 32'(T_WIDE);
      read(1'b1, v); chk("R12 impcode", v, e);

      // one-hot write sweep: R1 R3 R7 R9 R10 R11
      for (int i = 0; i < 32; i++) begin
         do_reset();
         write(32'h1 << i);
         e = (32'h1 << i) & (RW_M | BRK_M | FLAG_M);
         read(1'b0, v); chk($sformatf("R11 onehot bit %0d", i), v, e);
         chk($sformatf("R10 R9 outputs bit %0d", i), live_outs(), outs(e));
      end

      // all ones then zero: R9 R7 R3
      do_reset();
      write('1);
      read(1'b0, v); chk("R9 all ones", v, RW_M | BRK_M | FLAG_M);
      write('0);
      read(1'b0, v); chk("R7 R3 after zero", v, BRK_M);
      chk("R7 brk out", {31'd0, brk}, 32'd1);

      // R7 cleared by debug entry, R8 mirror
      @(negedge clk) in_dbg = 1'b1;
      @(negedge clk);
      chk("R7 brk cleared", {31'd0, brk}, 32'd0);
      read(1'b0, v); chk("R8 debug visible", v, 32'h0000_0008);
      @(negedge clk) in_dbg = 1'b0;
      write(32'h0000_0008);
      read(1'b0, v); chk("R8 write ignored", v, 32'd0);

      // R3 reset event
      @(negedge clk) rst_evt = 1'b1;
      @(negedge clk) rst_evt = 1'b0;
      read(1'b0, v); chk("R3 set by event", v, FLAG_M);
      write(FLAG_M);
      read(1'b0, v); chk("R3 write one keeps", v, FLAG_M);
      write('0);
      read(1'b0, v); chk("R3 write zero clears", v, 32'd0);

      // R4 R5 R6 access handshake
      access(1'b1);
      chk("R4 pending out", {31'd0, pend}, 32'd1);
      read(1'b0, v); chk("R5 write access", v, 32'h000C_0000);
      write(32'h0004_0000);
      chk("R4 write one no effect", {31'd0, pend}, 32'd1);
      access(1'b0);
      chk("R6 held while pending", {31'd0, pend}, 32'd1);
      write('0);
      chk("R4 cleared", {31'd0, pend}, 32'd0);
      @(negedge clk);
      chk("R6 promoted", {31'd0, pend}, 32'd1);
      read(1'b0, v); chk("R5 read access", v, 32'h0004_0000);
      write('0);
      @(negedge clk);
      chk("R6 slot empty", {31'd0, pend}, 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule